// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog down-counter that software can start, restart or stop only by writing a fixed pair of key words, one right after the other, to the control register. Once it is armed, the counter loads its reload value (all ones by default) and counts down by one on every clock. When it reaches zero it stops there and fires one event. The event is either a one-cycle reset request or a sticky interrupt flag. A bit in the setup register chooses which.

Reads of the control address return the live count. The setup address holds the event selector and one preserved bit. The status address shows the interrupt flag, and writing a 1 to bit 0 clears it. Every write is gated by the privilege input. A write made without privilege is dropped as if it never happened.

Top module: `seqlock_wdt`

## Requirements
- R1: After reset the count reads 0, the timer is stopped, setup reads 0, the status register and `irq_flag` are 0, and `rst_req` is 0.
- R2: A privileged write of 32'h1E1E1E1E to the control address (addr 0), followed on the very next write by 32'hE1E1E1E1, starts the timer and loads RELOAD. The count then drops by one per clock.
- R3: The same key pair, written while the timer is running, loads RELOAD again.
- R4: The pair 32'h1F1F1F1F followed by 32'hF1F1F1F1 stops the timer. The count then holds its value.
- R5: With setup bit 0 = 0, the clock edge that takes the count from 1 to 0 sets `irq_flag` (status bit 0). The count stays at 0 afterwards and `rst_req` stays low.
- R6: With setup bit 0 = 1, reaching terminal count gives exactly one single-cycle `rst_req` pulse and does not set `irq_flag`.
- R7: The setup register (addr 1) reads back bit 0 and bit 31 as written, and bits 30:1 always read as 0. When `rd_en` is low, `rdata` is 0.
- R8: A write with `priv` low changes nothing. It neither updates setup nor takes part in a key sequence.
- R9: A pending key sequence is cancelled by a wrong value at the control address, or by a write to any other address. A key write that is not part of a completed pair never changes the count.
- R10: Writing the first arm key while a sequence is already pending restarts the sequence. The next write must then be the second arm key.
- R11: A write of 1 to status bit 0 (addr 2) clears `irq_flag`, and a write of 0 leaves it alone. If a clear and a terminal-count set fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register select: 0 control/count, 1 setup, 2 status |
| wdata | input | 32 | Write data |
| priv | input | 1 | Privilege qualifier for writes |
| rdata | output | 32 | Read data, combinational |
| irq_flag | output | 1 | Sticky terminal-count interrupt flag |
| rst_req | output | 1 | One-cycle reset request at terminal count |

## Verification
Two functions can land on the same edge: the terminal-count set of the interrupt flag and a software clear of that same flag. The bench arms the timer and counts exactly RELOAD-1 clocks. It then issues the status clear write so that it lands on the edge where the count goes from 1 to 0. The flag must read 1 after that edge, which shows that the set wins. Earlier in the same test, a clear write on its own is checked to drop the flag.

// File: rtl/seqlock_wdt.sv
module seqlock_wdt #(
  parameter int          DW     = 32,
  parameter logic [31:0] RELOAD = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          priv,
  output logic [DW-1:0] rdata,
  output logic          irq_flag,
  output logic          rst_req
);
  localparam logic [1:0]    A_CTRL  = 2'd0;
  localparam logic [1:0]    A_SETUP = 2'd1;
  localparam logic [1:0]    A_STAT  = 2'd2;
  localparam logic [DW-1:0] K_ARM1  = DW'(32'h1E1E_1E1E);
  localparam logic [DW-1:0] K_ARM2  = DW'(32'hE1E1_E1E1);
  localparam logic [DW-1:0] K_DIS1  = DW'(32'h1F1F_1F1F);
  localparam logic [DW-1:0] K_DIS2  = DW'(32'hF1F1_F1F1);
  localparam logic [DW-1:0] LOADV   = DW'(RELOAD);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ARM, SQ_DIS} seq_t;

  seq_t          seq_q, seq_d;
  logic [DW-1:0] cnt_q;
  logic          run_q, act_q, keep_q;

  wire wr_ok   = wr_en && priv;
  wire ctrl_wr = wr_ok && (addr == A_CTRL);
  wire arm_go  = ctrl_wr && (seq_q == SQ_ARM) && (wdata == K_ARM2);
  wire dis_go  = ctrl_wr && (seq_q == SQ_DIS) && (wdata == K_DIS2);
  wire tick    = run_q && !dis_go && (cnt_q != '0);
  wire tc_hit  = tick && !arm_go && (cnt_q == DW'(1));
  wire clr_irq = wr_ok && (addr == A_STAT) && wdata[0];

  always_comb begin
    seq_d = seq_q;
    if (wr_ok) begin
      if (!ctrl_wr)             seq_d = SQ_IDLE;
      else if (wdata == K_ARM1) seq_d = SQ_ARM;
      else if (wdata == K_DIS1) seq_d = SQ_DIS;
      else                      seq_d = SQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q    <= SQ_IDLE;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      act_q    <= 1'b0;
      keep_q   <= 1'b0;
      irq_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      seq_q <= seq_d;
      if (arm_go) begin
        cnt_q <= LOADV;
        run_q <= 1'b1;
      end else begin
        if (dis_go) run_q <= 1'b0;
        if (tick)   cnt_q <= cnt_q - DW'(1);
      end
      if (wr_ok && addr == A_SETUP) begin
        act_q  <= wdata[0];
        keep_q <= wdata[DW-1];
      end
      if (tc_hit && !act_q) irq_flag <= 1'b1;
      else if (clr_irq)     irq_flag <= 1'b0;
      rst_req <= tc_hit && act_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rdata = cnt_q;
        A_SETUP: rdata = {keep_q, {(DW-2){1'b0}}, act_q};
        A_STAT:  rdata = {{(DW-1){1'b0}}, irq_flag};
        default: rdata = '0;
      endcase
    end
  end

  // R2
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_go |=> (cnt_q == LOADV) && run_q);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_go |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - DW'(1)));
  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !arm_go) |=> $stable(cnt_q));
  // R5
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !arm_go) |=> cnt_q == '0);
  // R5
  irq_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (cnt_q == '0) && !rst_req);
  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R6
  rst_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt_q == '0);
  // R8
  nopriv_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv) |=> $stable(act_q) && $stable(keep_q));
  // R11
  tc_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && !act_q) |=> irq_flag);
endmodule

// File: tb/test_seqlock_wdt.sv
module test_seqlock_wdt;
  localparam int RL = 40;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, priv = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_flag, rst_req;
  int total = 0, bad = 0;
  logic [31:0] v, w;

  seqlock_wdt #(.DW(32), .RELOAD(32'(RL))) i_seqlock_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .priv(priv), .rdata(rdata), .irq_flag(irq_flag), .rst_req(rst_req));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic p = 1'b1);
    wr_en = 1'b1; addr = a; wdata = d; priv = p;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; priv = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic arm(input logic p = 1'b1);
    wr(2'd0, 32'h1E1E_1E1E, p);
    wr(2'd0, 32'hE1E1_E1E1, p);
  endtask

  task automatic t_reset;
    rd(2'd0, v); eq("R1 count", v, 0);
    rd(2'd1, v); eq("R1 setup", v, 0);
    rd(2'd2, v); eq("R1 status", v, 0);
    eq("R1 irq", 32'(irq_flag), 0);
    eq("R1 rst_req", 32'(rst_req), 0);
    @(negedge clk); rd(2'd0, v); eq("R1 stopped", v, 0);
  endtask

  task automatic t_arm;
    arm();
    rd(2'd0, v); eq("R2 load", v, RL);
    @(negedge clk); rd(2'd0, v); eq("R2 step", v, RL - 1);
    repeat (3) @(negedge clk);
    rd(2'd0, v); eq("R2 run", v, RL - 4);
  endtask

  task automatic t_reload;
    repeat (5) @(negedge clk);
    arm();
    rd(2'd0, v); eq("R3 reload", v, RL);
  endtask

  task automatic t_disarm;
    repeat (3) @(negedge clk);
    wr(2'd0, 32'h1F1F_1F1F);
    wr(2'd0, 32'hF1F1_F1F1);
    rd(2'd0, v);
    repeat (6) @(negedge clk);
    rd(2'd0, w); eq("R4 hold", w, v);
    chk(v != 0 && v < RL, "R4 nonzero", v, RL - 5);
  endtask

  task automatic t_badseq;
    rd(2'd0, v);
    wr(2'd0, 32'h1E1E_1E1E); wr(2'd0, 32'h1234_5678); wr(2'd0, 32'hE1E1_E1E1);
    repeat (3) @(negedge clk);
    rd(2'd0, w); eq("R9 wrong value", w, v);
    wr(2'd0, 32'h1E1E_1E1E); wr(2'd1, 32'h0); wr(2'd0, 32'hE1E1_E1E1);
    repeat (3) @(negedge clk);
    rd(2'd0, w); eq("R9 other address", w, v);
    wr(2'd0, 32'hE1E1_E1E1);
    @(negedge clk); rd(2'd0, w); eq("R9 lone second key", w, v);
  endtask

  task automatic t_restart;
    rd(2'd0, v);
    wr(2'd0, 32'h1E1E_1E1E); wr(2'd0, 32'h1E1E_1E1E);
    rd(2'd0, w); eq("R10 no change", w, v);
    wr(2'd0, 32'hE1E1_E1E1);
    rd(2'd0, w); eq("R10 armed", w, RL);
    wr(2'd0, 32'h1F1F_1F1F); wr(2'd0, 32'hF1F1_F1F1);
  endtask

  task automatic t_setup;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); eq("R7 setup ones", v, 32'h8000_0001);
    rd_en = 1'b0; addr = 2'd1; #1; eq("R7 rd_en low", rdata, 0);
    @(negedge clk);
    wr(2'd1, 32'h0);
    rd(2'd1, v); eq("R7 setup zero", v, 0);
  endtask

  task automatic t_nopriv;
    wr(2'd1, 32'h8000_0001, 1'b0);
    rd(2'd1, v); eq("R8 setup", v, 0);
    rd(2'd0, v);
    arm(1'b0);
    repeat (2) @(negedge clk);
    rd(2'd0, w); eq("R8 no arm", w, v);
  endtask

  task automatic t_irq;
    arm();
    repeat (RL - 1) @(negedge clk);
    eq("R5 before tc", 32'(irq_flag), 0);
    @(negedge clk);
    eq("R5 irq set", 32'(irq_flag), 1);
    eq("R5 no rst_req", 32'(rst_req), 0);
    repeat (3) @(negedge clk);
    rd(2'd0, v); eq("R5 count stays 0", v, 0);
    rd(2'd2, v); eq("R5 status", v, 1);
  endtask

  task automatic t_clear;
    wr(2'd2, 32'h0);
    eq("R11 write 0 keeps", 32'(irq_flag), 1);
    wr(2'd2, 32'h1);
    eq("R11 cleared", 32'(irq_flag), 0);
    arm();
    repeat (RL - 1) @(negedge clk);
    wr(2'd2, 32'h1);
    eq("R11 set wins", 32'(irq_flag), 1);
    wr(2'd2, 32'h1);
  endtask

  task automatic t_rstmode;
    wr(2'd1, 32'h1);
    arm();
    repeat (RL - 1) @(negedge clk);
    eq("R6 before tc", 32'(rst_req), 0);
    @(negedge clk);
    eq("R6 pulse", 32'(rst_req), 1);
    @(negedge clk);
    eq("R6 one cycle", 32'(rst_req), 0);
    repeat (4) @(negedge clk);
    eq("R6 once", 32'(rst_req), 0);
    eq("R6 no irq", 32'(irq_flag), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm();
    t_reload();
    t_disarm();
    t_badseq();
    t_restart();
    t_setup();
    t_nopriv();
    t_irq();
    t_clear();
    t_rstmode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule